// File: doc/BRIEF.md
# Addressed Host-to-User Byte Receiver

This block is one of up to 128 endpoints that share a broadcast command bus driven by a host-side hub. Each endpoint carries a static 7-bit address. When the hub targets that address, the endpoint reports on its response bus whether it has room for another byte. It accepts bytes written into an open transfer and delivers them in order to user logic over an 8-bit valid/ready interface. All logic runs on the single 48 MHz interface clock.

The response buses of all endpoints are combined by bitwise OR before they reach the hub. Any endpoint that is not the current target must therefore drive all zeros. User logic may hold its ready input low at any time, even before a transfer starts. Doing so pauses delivery: the endpoint reports full to the hub and loses no data. The host gives up on a transfer after about 5 seconds of stall, so user logic must not hold ready low indefinitely.

Top module: `rxp_endpoint`

## Requirements
- R1: The endpoint is targeted only when the command bus has select (bit 7) high and its target field (bits 6:0) equals `ep_addr`. The other fields are strobe (bit 8), data byte (bits 16:9) and marker (bits 18:17: 01 opens a transfer, 10 closes it, 00 and 11 do nothing).
- R2: While the endpoint is not targeted, `rsp_bus` is all zeros.
- R3: `rsp_bus[0]` is 1 exactly when the endpoint is targeted and its buffer holds fewer than DEPTH bytes. `rsp_bus[9:1]` is always zero.
- R4: A targeted strobe is accepted when the transfer is open, or opens in the same cycle, and `rsp_bus[0]` is 1. Accepted bytes leave on `usr_data` in arrival order.
- R5: A strobe to this endpoint while no transfer is open is ignored.
- R6: `usr_valid` is high whenever at least one byte is buffered. A byte written at a clock edge is visible the cycle after that edge. A byte is consumed only on an edge where `usr_valid` and `usr_ready` are both high.
- R7: While `usr_valid` is high and `usr_ready` is low, `usr_valid` stays high and `usr_data` stays stable.
- R8: A close marker accepts the byte of its own cycle and then closes the transfer. Later strobes are ignored until the next open marker.
- R9: A synchronous reset (`rst` high at an edge) empties the buffer, drops `usr_valid` and closes the transfer.
- R10: The buffer holds DEPTH (default 4) bytes. A strobe that arrives while the buffer is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_addr | input | 7 | Static endpoint address |
| cmd_bus | input | 19 | Broadcast command bus from the hub |
| usr_ready | input | 1 | User logic accepts the presented byte |
| rsp_bus | output | 10 | Response to the hub, OR-combined with the other endpoints |
| usr_valid | output | 1 | A byte is presented on usr_data |
| usr_data | output | 8 | Byte delivered to user logic |

## Verification
The assertions assume that `ep_addr` stays constant between resets. They also assume that `usr_ready` and `cmd_bus` change only away from the clock edge. The bench drives every input at the falling edge and never changes the address. On purpose, it also breaks the hub's usual rule of writing only when the ready flag is set: it strobes into a full buffer, writes to other addresses, and sends strobes outside open transfers, so that the endpoint's own filtering is what keeps the data correct.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 19;
    localparam int RSP_W  = 10;

    typedef enum logic [1:0] {
        MK_NONE  = 2'b00,
        MK_OPEN  = 2'b01,
        MK_CLOSE = 2'b10,
        MK_RSVD  = 2'b11
    } marker_e;

    typedef struct packed {
        marker_e                 mark;
        logic [BYTE_W-1:0]       data;
        logic                    strobe;
        logic                    sel;
        logic [ADDR_W-1:0]       target;
    } cmd_t;

    function automatic logic cmd_hits(cmd_t c, logic [ADDR_W-1:0] me);
        return c.sel && (c.target == me);
    endfunction
endpackage

// File: rtl/rxp_decode.sv
module rxp_decode
    import rxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic              has_space,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              take_flag
);
    logic hit, opening, closing, open_q;

    always_comb begin
        hit       = cmd_hits(cmd, my_addr);
        opening   = hit && (cmd.mark == MK_OPEN);
        closing   = hit && (cmd.mark == MK_CLOSE);
        take_flag = hit && has_space;
        wr_en     = take_flag && cmd.strobe && (open_q || opening);
        wr_byte   = cmd.data;
    end

    always_ff @(posedge clk) begin
        if (rst)          open_q <= 1'b0;
        else if (opening) open_q <= 1'b1;
        else if (closing) open_q <= 1'b0;
    end

    AST_WR_IN_SESSION: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd.strobe && !open_q && !opening) |-> !wr_en); // R5
endmodule

// File: rtl/rxp_fifo.sv
module rxp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         not_empty,
    output logic         not_full,
    output logic [W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign not_empty = (count != '0);
    assign not_full  = (count != CNT_W'(DEPTH));
    assign do_push   = push && not_full;
    assign do_pop    = pop && not_empty;
    assign head      = slot[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(i))) slot[i] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!not_full && !pop) |=> $stable(count)); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R10
endmodule

// File: rtl/rxp_endpoint.sv
module rxp_endpoint
    import rxp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ep_addr,
    input  logic [CMD_W-1:0]  cmd_bus,
    input  logic              usr_ready,
    output logic [RSP_W-1:0]  rsp_bus,
    output logic              usr_valid,
    output logic [BYTE_W-1:0] usr_data
);
    cmd_t              cmd;
    logic              space, wr_en, take_flag;
    logic [BYTE_W-1:0] wr_byte;

    assign cmd = cmd_t'(cmd_bus);

    rxp_decode u_dec (
        .clk(clk), .rst(rst), .cmd(cmd), .my_addr(ep_addr),
        .has_space(space), .wr_en(wr_en), .wr_byte(wr_byte),
        .take_flag(take_flag)
    );

    rxp_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_buf (
        .clk(clk), .rst(rst), .push(wr_en), .push_data(wr_byte),
        .pop(usr_ready), .not_empty(usr_valid), .not_full(space),
        .head(usr_data)
    );

    assign rsp_bus = {{(RSP_W-1){1'b0}}, take_flag};

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(cmd_bus[7] && cmd_bus[6:0] == ep_addr) |-> rsp_bus == '0); // R2
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (usr_valid && !usr_ready) |=> (usr_valid && $stable(usr_data))); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !usr_valid); // R9
    AST_EMPTY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!usr_valid && rsp_bus[0] && cmd_bus[8] && cmd_bus[18:17] == 2'b01) |=> usr_valid); // R6
endmodule

// File: tb/sim_rxp_endpoint.sv
module sim_rxp_endpoint;
    localparam int DEPTH = 4;
    localparam logic [6:0] MY = 7'h2A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] bus = '0;
    logic        ready = 1'b0;
    logic [9:0]  rsp;
    logic        valid;
    logic [7:0]  data;

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [7:0] q[$];
    bit   open_m = 0;

    always #4 clk = ~clk;

    rxp_endpoint #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ep_addr(MY), .cmd_bus(bus),
        .usr_ready(ready), .rsp_bus(rsp), .usr_valid(valid), .usr_data(data)
    );

    function automatic logic [18:0] mk(logic sel, logic [6:0] a, logic stb,
                                       logic [7:0] d, logic [1:0] mark);
        return {mark, d, stb, sel, a};
    endfunction

    task automatic step(logic r, logic [18:0] b, logic rdy, string tag);
        logic       hit, exp_v, push, pop;
        logic [9:0] exp_rsp;
        logic [7:0] exp_d;
        @(negedge clk);
        rst = r; bus = b; ready = rdy;
        #1;
        hit     = b[7] && (b[6:0] == MY);
        exp_rsp = {9'b0, hit && (q.size() < DEPTH)};
        exp_v   = (q.size() != 0);
        exp_d   = exp_v ? q[0] : 8'h00;
        n_chk++;
        if (rsp !== exp_rsp || valid !== exp_v || (exp_v && data !== exp_d)) begin
            n_bad++;
            $display("FAIL %s: rsp=%h/%h valid=%b/%b data=%h/%h",
                     tag, rsp, exp_rsp, valid, exp_v, data, exp_d);
        end
        @(posedge clk);
        if (r) begin
            q.delete();
            open_m = 0;
        end else begin
            push = exp_rsp[0] && b[8] && (open_m || b[18:17] == 2'b01);
            pop  = exp_v && rdy;
            if (pop)  void'(q.pop_front());
            if (push) q.push_back(b[16:9]);
            if (hit && b[18:17] == 2'b01)      open_m = 1;
            else if (hit && b[18:17] == 2'b10) open_m = 0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished=0/1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        // R9 reset state
        step(1, '0, 0, "R9");
        step(1, mk(1, MY, 0, 0, 0), 0, "R9");
        // R1/R2: other endpoint opens and writes
        step(0, mk(1, 7'h2B, 1, 8'h11, 2'b01), 1, "R2");
        step(0, mk(1, 7'h2B, 1, 8'h12, 2'b00), 1, "R1");
        step(0, mk(0, MY, 1, 8'h13, 2'b01), 1, "R1");
        step(0, mk(1, MY, 0, 0, 0), 1, "R1");
        // R5: strobe with no open transfer
        step(0, mk(1, MY, 1, 8'h14, 2'b00), 1, "R5");
        step(0, mk(1, MY, 1, 8'h15, 2'b10), 1, "R5");
        step(0, mk(1, MY, 0, 0, 0), 1, "R5");
        // R4/R6: open with byte, stream with ready high
        step(0, mk(1, MY, 1, 8'hA0, 2'b01), 1, "R4");
        for (int i = 1; i < 6; i++) step(0, mk(1, MY, 1, 8'hA0 + 8'(i), 0), 1, "R6");
        step(0, mk(1, MY, 0, 0, 0), 1, "R6");
        step(0, mk(1, MY, 0, 0, 0), 1, "R6");
        // R7/R10: stall, fill and overfill
        for (int i = 0; i < DEPTH + 3; i++) step(0, mk(1, MY, 1, 8'hB0 + 8'(i), 0), 0, "R10");
        for (int i = 0; i < 4; i++) step(0, mk(0, 0, 0, 0, 0), 0, "R7");
        for (int i = 0; i < DEPTH + 1; i++) step(0, mk(0, 0, 0, 0, 0), 1, "R7");
        // R3: reserved bits and flag with partial fill
        step(0, mk(1, MY, 1, 8'hC0, 0), 0, "R3");
        step(0, mk(1, MY, 0, 0, 0), 0, "R3");
        // R8: close takes its byte then later strobes dropped
        step(0, mk(1, MY, 1, 8'hC1, 2'b10), 1, "R8");
        step(0, mk(1, MY, 1, 8'hC2, 0), 1, "R8");
        step(0, mk(1, MY, 1, 8'hC3, 0), 1, "R8");
        step(0, mk(1, MY, 0, 0, 0), 1, "R8");
        // R9: reset with buffered bytes and open transfer
        step(0, mk(1, MY, 1, 8'hD0, 2'b01), 0, "R9");
        step(0, mk(1, MY, 1, 8'hD1, 0), 0, "R9");
        step(1, mk(1, MY, 0, 0, 0), 0, "R9");
        step(0, mk(1, MY, 1, 8'hD2, 0), 1, "R9");
        step(0, mk(1, MY, 0, 0, 0), 1, "R9");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(0, mk(lf[0], lf[1] ? MY : {lf[9:4], 1'b1} ^ MY, lf[2], lf[15:8],
                       lf[3] ? lf[5:4] : 2'b00), lf[6] | lf[7], "R4");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule